// File: doc/BRIEF.md
# Multi-Channel ADC Pattern Checker

This block is test logic for a bank of ADC channels. During a link or board check the ADC devices are set to send a fixed test word. The checker compares the word from every channel against a programmed reference, counts how many sample cycles have been checked, and records which channels have ever sent a word that did not match.

All channel samples arrive together as one flat bundle with a single valid strobe. Two control bits steer the block. The enable bit starts a test, and each new test clears the earlier results. The pause bit freezes checking but keeps the results. The reference register is wider than the native ADC word and is MSB-aligned, so only its upper bits take part in the comparison.

Both results are registered outputs. They stay readable while the checker is idle or paused.

Top module: `adc_pattern_checker`

## Requirements
- R1: A synchronous active-high `rst` sets `words_checked` to 0 and every bit of `fail_mask` to 0.
- R2: A rising edge of `ctl[0]` (enable) starts a test and clears the counter and the mask. Holding `ctl[0]` high in later cycles does not clear them again.
- R3: While `ctl[1]` (pause) is 1, no sample is checked and both outputs hold their values. A start edge that arrives during a pause still clears the results.
- R4: In each cycle where `ctl[0]`=1, `ctl[1]`=0 and `smp_valid`=1, the counter goes up by one. Both outputs show the result after the next rising clock edge.
- R5: Channel c occupies `smp_data[c*SAMPLE_W +: SAMPLE_W]` and drives `fail_mask[c]`. It is compared with `pattern[PATTERN_W-1 -: SAMPLE_W]`. The lower `PATTERN_W-SAMPLE_W` bits of `pattern` have no effect.
- R6: Failure bits are sticky. A bit is set on a mismatch and clears only on reset or on a test start.
- R7: The counter saturates at all ones and does not wrap.
- R8: While `ctl[0]`=0, the checker is idle: valid samples are ignored and the outputs hold.
- R9: A sample that is valid in the same cycle as the start edge is checked against the cleared state. The counter then reads 1, and the mask holds only that sample's mismatches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl | input | 2 | Bit 0 enable, bit 1 pause |
| pattern | input | PATTERN_W | MSB-aligned reference word |
| smp_valid | input | 1 | All channel samples valid this cycle |
| smp_data | input | NUM_CH*SAMPLE_W | Channel samples, channel 0 in the lowest bits |
| words_checked | output | CNT_W | Saturating count of checked sample cycles |
| fail_mask | output | NUM_CH | Sticky per-channel mismatch flags |

## Verification
The bench checks these corner cases:
- **Start edge.** It re-raises enable and also holds it high across many cycles. A design that treats the level as the clear would keep resetting the counter at 1.
- **Start during a pause.** It raises enable while pause is set. A checker that clears only when it is running would keep stale results.
- **Low reference bits.** It changes only the low bits of the reference. A design that compares the full register would flag every channel.
- **Sample on the start edge.** It sends a valid sample on the same cycle as the start. A design that clears after comparing would lose that sample.
- **Counter width.** A narrow-counter instance is driven past its limit. A wrapping counter would read back a small number.

// File: rtl/apc_pkg.sv
package apc_pkg;
  // bit positions inside the control word
  localparam int unsigned CTL_EN    = 0;
  localparam int unsigned CTL_PAUSE = 1;
  localparam int unsigned CTL_W     = 2;
endpackage

// File: rtl/apc_start_edge.sv
module apc_start_edge (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic start
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en;
  end

  assign start = en & ~en_q;
endmodule

// File: rtl/apc_sat_counter.sv
module apc_sat_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)                         cnt <= '0;
    else if (clr)                    cnt <= inc ? CNT_ONE : '0;
    else if (inc && cnt != CNT_MAX)  cnt <= cnt + CNT_ONE;
  end
endmodule

// File: rtl/apc_lane_cmp.sv
module apc_lane_cmp #(
  parameter int unsigned SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                chk,
  input  logic [SAMPLE_W-1:0] ref_word,
  input  logic [SAMPLE_W-1:0] smp,
  output logic                fail
);
  logic miss;
  assign miss = (smp != ref_word);

  always_ff @(posedge clk) begin
    if (rst)      fail <= 1'b0;
    else if (clr) fail <= chk & miss;
    else if (chk) fail <= fail | miss;
  end
endmodule

// File: rtl/adc_pattern_checker.sv
module adc_pattern_checker
  import apc_pkg::*;
#(
  parameter int unsigned NUM_CH    = 16,
  parameter int unsigned SAMPLE_W  = 12,
  parameter int unsigned PATTERN_W = 16,
  parameter int unsigned CNT_W     = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CTL_W-1:0]             ctl,
  input  logic [PATTERN_W-1:0]         pattern,
  input  logic                         smp_valid,
  input  logic [NUM_CH*SAMPLE_W-1:0]   smp_data,
  output logic [CNT_W-1:0]             words_checked,
  output logic [NUM_CH-1:0]            fail_mask
);
  localparam int unsigned LSB_DROP = PATTERN_W - SAMPLE_W;

  initial begin
    if (PATTERN_W < SAMPLE_W) $error("PATTERN_W must be at least SAMPLE_W");
  end

  logic start;
  logic chk;
  logic [SAMPLE_W-1:0] ref_word;
  logic unused_pat;

  assign ref_word   = pattern[PATTERN_W-1 -: SAMPLE_W];
  assign unused_pat = ^pattern[LSB_DROP +: 1] ^ ^pattern;
  assign chk        = ctl[CTL_EN] & ~ctl[CTL_PAUSE] & smp_valid;

  apc_start_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .en    (ctl[CTL_EN]),
    .start (start)
  );

  apc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (start),
    .inc (chk),
    .cnt (words_checked)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    apc_lane_cmp #(.SAMPLE_W(SAMPLE_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .clr      (start),
      .chk      (chk),
      .ref_word (ref_word),
      .smp      (smp_data[c*SAMPLE_W +: SAMPLE_W]),
      .fail     (fail_mask[c])
    );
  end

  // R1: outputs are zero right after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (words_checked == '0 && fail_mask == '0));

  // R2: a start edge without a checked sample leaves cleared results
  a_r2_start_clear: assert property (@(posedge clk) disable iff (rst)
    (start && !chk) |=> (words_checked == '0 && fail_mask == '0));

  // R3 / R8: paused or idle without a start edge holds the results
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!start && (ctl[CTL_PAUSE] || !ctl[CTL_EN]))
      |=> ($stable(words_checked) && $stable(fail_mask)));

  // R4: one step per checked cycle below the limit
  a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
    (chk && !start && words_checked != '1)
      |=> (words_checked == $past(words_checked) + CNT_W'(1)));

  // R6: failure bits never drop outside a start
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    !start |=> ((fail_mask & $past(fail_mask)) == $past(fail_mask)));

  // R7: the counter stays at its limit
  a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
    (!start && words_checked == '1) |=> (words_checked == '1));

  // R9: a sample checked on the start edge gives a count of one
  a_r9_start_sample: assert property (@(posedge clk) disable iff (rst)
    (start && chk) |=> (words_checked == CNT_W'(1)));
endmodule

// File: tb/adc_pattern_checker_tb_top.sv
module adc_pattern_checker_tb_top;
  localparam int unsigned NCH = 4;
  localparam int unsigned SW  = 12;
  localparam int unsigned PW  = 16;
  localparam int unsigned CW  = 64;
  localparam int unsigned SCW = 3;

  typedef struct packed {
    logic [1:0]      ctl;
    logic            vld;
    logic [PW-1:0]   pat;
    logic [NCH*SW-1:0] data;
    logic [7:0]      cnt;
    logic [NCH-1:0]  mask;
    logic [7:0]      req;
  } vec_t;

  localparam int NV = 16;
  // data hex reads ch3 ch2 ch1 ch0; reference upper bits are ABC
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b1, 16'hABC0, 48'hABCABCABCABC, 8'd0, 4'b0000, 8'd8}, // R8 idle
    '{2'b01, 1'b1, 16'hABC0, 48'hABCABCABCABC, 8'd1, 4'b0000, 8'd9}, // R9 start+sample
    '{2'b01, 1'b1, 16'hABC0, 48'hABCABCABCABC, 8'd2, 4'b0000, 8'd4}, // R4
    '{2'b01, 1'b0, 16'hABC0, 48'h000000000000, 8'd2, 4'b0000, 8'd4}, // R4 no valid
    '{2'b01, 1'b1, 16'hABCF, 48'hABCABCABCABC, 8'd3, 4'b0000, 8'd5}, // R5 low bits
    '{2'b01, 1'b1, 16'hABC0, 48'hABCABCABDABC, 8'd4, 4'b0010, 8'd5}, // R5 ch1
    '{2'b01, 1'b1, 16'hABC0, 48'hABCABCABCABC, 8'd5, 4'b0010, 8'd6}, // R6 sticky
    '{2'b11, 1'b1, 16'hABC0, 48'h000ABCABCABC, 8'd5, 4'b0010, 8'd3}, // R3 pause
    '{2'b01, 1'b1, 16'hABC0, 48'h000ABCABCABC, 8'd6, 4'b1010, 8'd5}, // R5 ch3
    '{2'b00, 1'b1, 16'hABC0, 48'hABCABCABC000, 8'd6, 4'b1010, 8'd8}, // R8 idle
    '{2'b01, 1'b1, 16'hABC0, 48'hABC000ABCABC, 8'd1, 4'b0100, 8'd2}, // R2 restart
    '{2'b01, 1'b1, 16'hABC0, 48'hABCABCABCABC, 8'd2, 4'b0100, 8'd2}, // R2 no reclear
    '{2'b11, 1'b1, 16'hABC0, 48'h000000000000, 8'd2, 4'b0100, 8'd3}, // R3 pause
    '{2'b10, 1'b1, 16'hABC0, 48'h000000000000, 8'd2, 4'b0100, 8'd8}, // R8 low en
    '{2'b11, 1'b1, 16'hABC0, 48'h000000000000, 8'd0, 4'b0000, 8'd3}, // R3 start in pause
    '{2'b01, 1'b1, 16'hABC0, 48'h000000000000, 8'd1, 4'b1111, 8'd5}  // R5 all lanes
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] ctl = '0;
  logic [PW-1:0] pattern = '0;
  logic smp_valid = 1'b0;
  logic [NCH*SW-1:0] smp_data = '0;
  logic [CW-1:0] words_checked;
  logic [NCH-1:0] fail_mask;

  logic [1:0] s_ctl = '0;
  logic s_valid = 1'b0;
  logic [SW-1:0] s_data = '0;
  logic [SCW-1:0] s_cnt;
  logic [0:0] s_mask;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  adc_pattern_checker #(.NUM_CH(NCH), .SAMPLE_W(SW), .PATTERN_W(PW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .ctl(ctl), .pattern(pattern), .smp_valid(smp_valid),
    .smp_data(smp_data), .words_checked(words_checked), .fail_mask(fail_mask));

  adc_pattern_checker #(.NUM_CH(1), .SAMPLE_W(SW), .PATTERN_W(PW), .CNT_W(SCW)) sat_i (
    .clk(clk), .rst(rst), .ctl(s_ctl), .pattern(16'h5550), .smp_valid(s_valid),
    .smp_data(s_data), .words_checked(s_cnt), .fail_mask(s_mask));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 count after reset", words_checked, 64'd0);
    check("R1 mask after reset", 64'(fail_mask), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      ctl = VECS[i].ctl;
      smp_valid = VECS[i].vld;
      pattern = VECS[i].pat;
      smp_data = VECS[i].data;
      @(negedge clk);
      check($sformatf("R%0d row %0d count", VECS[i].req, i), words_checked, 64'(VECS[i].cnt));
      check($sformatf("R%0d row %0d mask", VECS[i].req, i), 64'(fail_mask), 64'(VECS[i].mask));
    end

    // R2: enable held high for many cycles never clears again
    ctl = 2'b01; smp_valid = 1'b1; smp_data = 48'hABCABCABCABC;
    repeat (20) @(negedge clk);
    check("R2 long hold count", words_checked, 64'd21);
    check("R6 long hold mask", 64'(fail_mask), 64'hF);

    // R1: reset in the middle of a run
    rst = 1'b1; smp_valid = 1'b0;
    @(negedge clk);
    check("R1 mid-run count", words_checked, 64'd0);
    check("R1 mid-run mask", 64'(fail_mask), 64'd0);
    rst = 1'b0; ctl = 2'b00;
    @(negedge clk);

    // R7: narrow counter saturates at 7
    s_ctl = 2'b01; s_valid = 1'b1; s_data = 12'h555;
    repeat (10) @(negedge clk);
    check("R7 saturated count", 64'(s_cnt), 64'd7);
    check("R5 narrow lane match", 64'(s_mask), 64'd0);
    s_data = 12'h554;
    @(negedge clk);
    check("R7 still saturated", 64'(s_cnt), 64'd7);
    check("R5 narrow lane miss", 64'(s_mask), 64'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule